// File: doc/BRIEF.md
# Hit-Driven Conversion Sequencer

This block runs the digitization cycle of one event in a multichannel time digitizer. A common start opens an acceptance window. The window begins with a short guard interval, and during the rest of it the block collects the stop flags of the channels as a bit mask. The block can then wait for the trailing edge of a measure-pause input, if that wait is enabled. After that it spends a fixed overhead and steps a shared converter through the channels that were hit. It visits each hit channel once, lowest index first, and gives each one a slot of fixed length. Channels that saw no stop cost no time, so a conversion lasts the overhead plus one slot for each hit.

Each channel to convert goes out as a valid/ready transfer that carries the channel index. The converter may hold ready low to apply back-pressure. While it does, the channel index and valid stay unchanged, and the stall cycles add to the conversion time. A conversion-in-progress flag covers the overhead and all slots. A one-cycle done pulse ends each event and reports how many channels were converted, with a flag for an event that had no hits. A fast clear drops the event and returns the block to idle, except while the downstream event buffer reports full. All times are in clock cycles and are set by parameters.

Top module: `hit_conv_seq`

## Requirements
- R1: Only channels whose stop flag was seen during the acceptance part of the window are offered for conversion, each exactly once, and `done_hits_o` equals their number.
- R2: Hit channels are offered in strictly ascending index order.
- R3: A channel whose index is at or above `active_ch_i` (range 1 to NCH) is never offered, even when its stop flag is set.
- R4: The window lasts GUARD_CYC+FULL_CYC cycles after the start is sampled. Stop flags seen in its first GUARD_CYC cycles are ignored.
- R5: With the wait disabled, `cip_o` is high for exactly OVH_CYC + n*SLOT_CYC + s cycles, where n is the number of hits and s is the number of cycles with `conv_valid_o` high and `conv_ready_i` low. `done_o` rises in the cycle after `cip_o` falls.
- R6: An event with no hits still spends OVH_CYC cycles with `cip_o` high. It then pulses `done_o` with `done_empty_o`=1 and `done_hits_o`=0.
- R7: When `pause_en_i` is 1 at the end of the window, `cip_o` stays low until `pause_i` is seen going from 1 to 0. The overhead starts after that edge.
- R8: A fast clear (`fclr_i`=1 with `buf_full_i`=0) makes `cip_o` and `conv_valid_o` low in the next cycle. No `done_o` follows for the dropped event.
- R9: `fclr_i` has no effect while `buf_full_i` is 1, and the event runs to its normal done.
- R10: A `start_i` pulse while an event is in progress is ignored and does not queue a later event.
- R11: While `conv_valid_o` is 1 and `conv_ready_i` is 0, `conv_valid_o` stays 1 in the next cycle and `conv_ch_o` does not change.
- R12: After reset, `cip_o`, `conv_valid_o` and `done_o` are 0.
- R13: `done_o` is high for a single cycle, with `cip_o` and `conv_valid_o` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Common start pulse; acted on only when idle |
| hit_mask_i | input | NCH | Per-channel stop flags, sampled every window cycle |
| active_ch_i | input | $clog2(NCH+1) | Number of active channels, 1 to NCH |
| pause_en_i | input | 1 | Wait for the pause trailing edge before converting |
| pause_i | input | 1 | Measure-pause level |
| fclr_i | input | 1 | Fast clear |
| buf_full_i | input | 1 | Downstream event buffer full; blocks fast clear |
| conv_valid_o | output | 1 | Channel index offered to the converter |
| conv_ready_i | input | 1 | Converter accepts the offered channel |
| conv_ch_o | output | $clog2(NCH) | Channel index to convert |
| cip_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-event pulse |
| done_hits_o | output | $clog2(NCH+1) | Number of channels converted, valid with done_o |
| done_empty_o | output | 1 | Event ended with no hits, valid with done_o |

## Verification
The bench builds the block with 16 channels, a 2-cycle guard, a 6-cycle acceptance span, a 12-cycle overhead and a 4-cycle slot. With these sizes an event that hits every channel fits in under a hundred cycles. This lets the bench run many random hit patterns, random ready stalls, an all-channels event, a reduced active count, guard-only stops, a pause wait and both fast-clear cases within the run. The small slot and overhead values also keep the exact cycle count of R5 short enough to check on every event.

// File: rtl/hcs_pkg.sv
`timescale 1ns/1ps
package hcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_WIN   = 3'd1,
    S_PAUSE = 3'd2,
    S_OVH   = 3'd3,
    S_EMIT  = 3'd4,
    S_SLOT  = 3'd5,
    S_DONE  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/hcs_hitlatch.sv
`timescale 1ns/1ps
// Accumulates stop flags during the acceptance span and retires
// one channel per accepted conversion.
module hcs_hitlatch #(
  parameter int NCH = 64,
  localparam int CIW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           capture_i,
  input  logic [NCH-1:0] hits_i,
  input  logic [NCH-1:0] act_mask_i,
  input  logic           consume_i,
  input  logic [CIW-1:0] consume_idx_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] drop;
  logic [NCH-1:0] add;

  always_comb begin
    drop = '0;
    if (consume_i) drop[consume_idx_i] = 1'b1;
    add = capture_i ? (hits_i & act_mask_i) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= '0;
    else if (clr_i) pend_q <= '0;
    else            pend_q <= (pend_q | add) & ~drop;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/hcs_pick.sv
`timescale 1ns/1ps
// Lowest-index selector over the pending mask.
module hcs_pick #(
  parameter int NCH = 64,
  localparam int CIW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend_i,
  output logic           any_o,
  output logic [CIW-1:0] idx_o
);
  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = CIW'(i);
    end
  end
endmodule

// File: rtl/hcs_ctrl.sv
`timescale 1ns/1ps
// Event sequencing: window, optional pause wait, overhead, per-hit slots.
module hcs_ctrl
  import hcs_pkg::*;
#(
  parameter int NCH       = 64,
  parameter int GUARD_CYC = 9,
  parameter int FULL_CYC  = 20,
  parameter int OVH_CYC   = 2000,
  parameter int SLOT_CYC  = 500,
  localparam int CIW     = $clog2(NCH),
  localparam int ACW     = $clog2(NCH + 1),
  localparam int WIN_LEN = GUARD_CYC + FULL_CYC,
  localparam int MAXA    = (WIN_LEN > OVH_CYC) ? WIN_LEN : OVH_CYC,
  localparam int MAXC    = (MAXA > SLOT_CYC) ? MAXA : SLOT_CYC,
  localparam int CNTW    = $clog2(MAXC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           pause_en_i,
  input  logic           pause_i,
  input  logic           fclr_i,
  input  logic           buf_full_i,
  input  logic           any_i,
  input  logic [CIW-1:0] idx_i,
  input  logic           ready_i,
  output logic           clr_o,
  output logic           capture_o,
  output logic           consume_o,
  output logic           valid_o,
  output logic [CIW-1:0] ch_o,
  output logic           cip_o,
  output logic           done_o,
  output logic [ACW-1:0] nhit_o
);
  seq_state_t     state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CIW-1:0]  ch_q, ch_d;
  logic [ACW-1:0]  nhit_q, nhit_d;
  logic            pause_q;
  logic            clear_ok;

  assign clear_ok = fclr_i && !buf_full_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ch_d      = ch_q;
    nhit_d    = nhit_q;
    capture_o = 1'b0;
    consume_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_WIN;
          cnt_d   = '0;
          nhit_d  = '0;
        end
      end
      S_WIN: begin
        capture_o = (cnt_q >= CNTW'(GUARD_CYC));
        if (cnt_q == CNTW'(WIN_LEN - 1)) begin
          cnt_d   = '0;
          state_d = pause_en_i ? S_PAUSE : S_OVH;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      S_PAUSE: begin
        if (pause_q && !pause_i) begin
          state_d = S_OVH;
          cnt_d   = '0;
        end
      end
      S_OVH: begin
        if (cnt_q == CNTW'(OVH_CYC - 1)) begin
          cnt_d = '0;
          if (any_i) begin
            state_d = S_EMIT;
            ch_d    = idx_i;
          end else begin
            state_d = S_DONE;
          end
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      S_EMIT: begin
        if (ready_i) begin
          consume_o = 1'b1;
          nhit_d    = nhit_q + ACW'(1);
          state_d   = S_SLOT;
          cnt_d     = '0;
        end
      end
      S_SLOT: begin
        if (cnt_q == CNTW'(SLOT_CYC - 2)) begin
          cnt_d = '0;
          if (any_i) begin
            state_d = S_EMIT;
            ch_d    = idx_i;
          end else begin
            state_d = S_DONE;
          end
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (clear_ok) begin
      state_d = S_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      nhit_q  <= '0;
      pause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ch_q    <= ch_d;
      nhit_q  <= nhit_d;
      pause_q <= pause_i;
    end
  end

  assign clr_o   = (state_q == S_IDLE);
  assign valid_o = (state_q == S_EMIT);
  assign ch_o    = ch_q;
  assign cip_o   = (state_q == S_OVH) || (state_q == S_EMIT) || (state_q == S_SLOT);
  assign done_o  = (state_q == S_DONE);
  assign nhit_o  = nhit_q;
endmodule

// File: rtl/hit_conv_seq.sv
`timescale 1ns/1ps
module hit_conv_seq #(
  parameter int NCH       = 64,
  parameter int GUARD_CYC = 9,
  parameter int FULL_CYC  = 20,
  parameter int OVH_CYC   = 2000,
  parameter int SLOT_CYC  = 500,
  localparam int CIW = $clog2(NCH),
  localparam int ACW = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NCH-1:0] hit_mask_i,
  input  logic [ACW-1:0] active_ch_i,
  input  logic           pause_en_i,
  input  logic           pause_i,
  input  logic           fclr_i,
  input  logic           buf_full_i,
  output logic           conv_valid_o,
  input  logic           conv_ready_i,
  output logic [CIW-1:0] conv_ch_o,
  output logic           cip_o,
  output logic           done_o,
  output logic [ACW-1:0] done_hits_o,
  output logic           done_empty_o
);
  logic [NCH-1:0] act_mask;
  logic [NCH-1:0] pend;
  logic           any_pend;
  logic [CIW-1:0] pick_idx;
  logic           clr, capture, consume;
  logic [ACW-1:0] nhit;

  for (genvar g = 0; g < NCH; g++) begin : g_act
    assign act_mask[g] = (ACW'(g) < active_ch_i);
  end

  hcs_hitlatch #(.NCH(NCH)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .capture_i(capture),
    .hits_i(hit_mask_i), .act_mask_i(act_mask), .consume_i(consume),
    .consume_idx_i(conv_ch_o), .pend_o(pend)
  );

  hcs_pick #(.NCH(NCH)) u_pick (
    .pend_i(pend), .any_o(any_pend), .idx_o(pick_idx)
  );

  hcs_ctrl #(
    .NCH(NCH), .GUARD_CYC(GUARD_CYC), .FULL_CYC(FULL_CYC),
    .OVH_CYC(OVH_CYC), .SLOT_CYC(SLOT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pause_en_i(pause_en_i),
    .pause_i(pause_i), .fclr_i(fclr_i), .buf_full_i(buf_full_i),
    .any_i(any_pend), .idx_i(pick_idx), .ready_i(conv_ready_i),
    .clr_o(clr), .capture_o(capture), .consume_o(consume),
    .valid_o(conv_valid_o), .ch_o(conv_ch_o), .cip_o(cip_o),
    .done_o(done_o), .nhit_o(nhit)
  );

  assign done_hits_o  = nhit;
  assign done_empty_o = done_o && (nhit == '0);
endmodule

// File: rtl/hcs_checker.sv
`timescale 1ns/1ps
module hcs_checker #(
  parameter int NCH = 64,
  localparam int CIW = $clog2(NCH),
  localparam int ACW = $clog2(NCH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fclr_i,
  input logic           buf_full_i,
  input logic           conv_valid_o,
  input logic           conv_ready_i,
  input logic [CIW-1:0] conv_ch_o,
  input logic           cip_o,
  input logic           done_o,
  input logic [ACW-1:0] done_hits_o,
  input logic           done_empty_o
);
  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o && !conv_ready_i && !(fclr_i && !buf_full_i))
      |=> (conv_valid_o && $stable(conv_ch_o)));

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R13
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cip_o && !conv_valid_o));

  // R5
  valid_in_cip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid_o |-> cip_o);

  // R8
  fclr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fclr_i && !buf_full_i) |=> (!cip_o && !conv_valid_o && !done_o));

  // R6
  empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_empty_o) |-> (done_hits_o == '0));
endmodule

bind hit_conv_seq hcs_checker #(.NCH(NCH)) u_hcs_chk (
  .clk(clk), .rst_n(rst_n), .fclr_i(fclr_i), .buf_full_i(buf_full_i),
  .conv_valid_o(conv_valid_o), .conv_ready_i(conv_ready_i),
  .conv_ch_o(conv_ch_o), .cip_o(cip_o), .done_o(done_o),
  .done_hits_o(done_hits_o), .done_empty_o(done_empty_o)
);

// File: tb/hit_conv_seq_tb_top.sv
`timescale 1ns/1ps
module hit_conv_seq_tb_top;
  localparam int NCH   = 16;
  localparam int GUARD = 2;
  localparam int FULL  = 6;
  localparam int OVH   = 12;
  localparam int SLOT  = 4;
  localparam int WIN   = GUARD + FULL;
  localparam int CIW   = $clog2(NCH);
  localparam int ACW   = $clog2(NCH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NCH-1:0] hit_mask_i = '0;
  logic [ACW-1:0] active_ch_i = ACW'(NCH);
  logic pause_en_i = 1'b0, pause_i = 1'b0, fclr_i = 1'b0, buf_full_i = 1'b0;
  logic conv_ready_i = 1'b1;
  logic conv_valid_o, cip_o, done_o, done_empty_o;
  logic [CIW-1:0] conv_ch_o;
  logic [ACW-1:0] done_hits_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hit_conv_seq #(
    .NCH(NCH), .GUARD_CYC(GUARD), .FULL_CYC(FULL), .OVH_CYC(OVH), .SLOT_CYC(SLOT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_mask_i(hit_mask_i),
    .active_ch_i(active_ch_i), .pause_en_i(pause_en_i), .pause_i(pause_i),
    .fclr_i(fclr_i), .buf_full_i(buf_full_i), .conv_valid_o(conv_valid_o),
    .conv_ready_i(conv_ready_i), .conv_ch_o(conv_ch_o), .cip_o(cip_o),
    .done_o(done_o), .done_hits_o(done_hits_o), .done_empty_o(done_empty_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] mask_of(input int act);
    logic [NCH-1:0] m = '0;
    for (int i = 0; i < NCH; i++) if (i < act) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int lowest(input logic [NCH-1:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return -1;
  endfunction

  // mode: 0 random sparse, 1 none, 2 all ones in guard only, 3 all ones after guard
  task automatic run_event(input int act, input int mode, input bit pen, input int pdelay,
                           input bit rrand, input bit stray, input int fclr_at, input bit bfull);
    logic [NCH-1:0] exp, rem, h;
    int stalls, cipn, prev_ch, n;
    bit prev_stall, got_done, pause_bad;
    exp = '0; stalls = 0; cipn = 0; prev_ch = 0; prev_stall = 0; got_done = 0; pause_bad = 0;
    @(negedge clk);
    active_ch_i = ACW'(act); pause_en_i = pen; pause_i = pen; buf_full_i = bfull;
    start_i = 1'b1; hit_mask_i = '0;
    for (int w = 0; w < WIN; w++) begin
      @(negedge clk);
      start_i = 1'b0;
      case (mode)
        0: h = NCH'($urandom & $urandom);
        1: h = '0;
        2: h = (w < GUARD) ? '1 : '0;
        default: h = (w >= GUARD) ? '1 : '0;
      endcase
      if (w == 0 && mode == 0) h = h | NCH'(1 << NCH-1);  // stop in guard span, R4
      hit_mask_i = h;
      if (w >= GUARD) exp |= h & mask_of(act);
    end
    @(negedge clk);
    hit_mask_i = '0;
    rem = exp; n = $countones(exp);
    for (int c = 0; c < 3000; c++) begin
      if (pen && c <= pdelay && cip_o) pause_bad = 1;
      if (pen && c == pdelay) pause_i = 1'b0;
      start_i = (stray && c == 5);
      if (fclr_at >= 0 && c == fclr_at + 1 && !bfull) begin
        chk(!cip_o && !conv_valid_o, "R8 abort", int'(cip_o), 0);
      end
      fclr_i = (fclr_at >= 0 && c == fclr_at);
      if (fclr_at >= 0 && !bfull && c > fclr_at + 8) break;
      if (done_o) begin
        got_done = 1;
        if (fclr_at >= 0 && !bfull) chk(0, "R8 no done after clear", 1, 0);
        break;
      end
      if (conv_valid_o) begin
        if (prev_stall) chk(int'(conv_ch_o) == prev_ch, "R11 hold", conv_ch_o, prev_ch);
        chk(int'(conv_ch_o) == lowest(rem), "R1 R2 R3 order", conv_ch_o, lowest(rem));
        conv_ready_i = rrand ? ($urandom % 3 != 0) : 1'b1;
        prev_ch = conv_ch_o;
        if (conv_ready_i) begin
          if (lowest(rem) >= 0) rem[lowest(rem)] = 1'b0;
          prev_stall = 0;
        end else begin
          stalls++;
          prev_stall = 1;
        end
      end else begin
        conv_ready_i = rrand ? $urandom % 2 == 1 : 1'b1;
        prev_stall = 0;
      end
      if (cip_o) cipn++;
      @(negedge clk);
    end
    fclr_i = 1'b0; start_i = 1'b0; conv_ready_i = 1'b1;
    if (pen) chk(!pause_bad, "R7 wait for trailing edge", int'(pause_bad), 0);
    if (fclr_at >= 0 && !bfull) begin
      chk(!got_done && !cip_o, "R8 idle after clear", int'(cip_o), 0);
    end else begin
      if (bfull && fclr_at >= 0) chk(got_done, "R9 clear ignored when full", int'(got_done), 1);
      chk(got_done, "R5 done reached", int'(got_done), 1);
      chk(int'(done_hits_o) == n, "R1 R3 R4 hit count", done_hits_o, n);
      chk(done_empty_o == (n == 0), "R6 empty flag", done_empty_o, int'(n == 0));
      chk(cipn == OVH + n * SLOT + stalls, "R5 cip length", cipn, OVH + n * SLOT + stalls);
      chk(rem == '0, "R1 all converted", $countones(rem), 0);
      @(negedge clk);
      chk(!done_o, "R13 done one cycle", done_o, 0);
      if (stray) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk(!cip_o, "R10 stray start ignored", cip_o, 0);
        end
      end
    end
    pause_en_i = 1'b0; pause_i = 1'b0; buf_full_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    chk(!cip_o && !conv_valid_o && !done_o, "R12 reset outputs", int'(cip_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cip_o && !conv_valid_o && !done_o, "R12 idle after reset", int'(cip_o), 0);
    run_event(NCH, 1, 0, 0, 0, 0, -1, 0);   // R6 zero hits
    run_event(NCH, 2, 0, 0, 0, 0, -1, 0);   // R4 guard-only stops
    run_event(NCH, 3, 0, 0, 0, 0, -1, 0);   // R1 all channels
    run_event(5,   3, 0, 0, 1, 0, -1, 0);   // R3 reduced active count
    run_event(1,   3, 0, 0, 0, 0, -1, 0);   // R3 single active channel
    run_event(NCH, 0, 1, 20, 0, 0, -1, 0);  // R7 pause wait
    run_event(NCH, 3, 0, 0, 0, 0, 20, 0);   // R8 fast clear
    run_event(NCH, 1, 0, 0, 1, 0, -1, 0);   // R8 next event after clear
    run_event(NCH, 3, 0, 0, 0, 0, 20, 1);   // R9 clear while buffer full
    run_event(NCH, 0, 0, 0, 0, 1, -1, 0);   // R10 stray start
    for (int e = 0; e < 25; e++) begin
      run_event(1 + ($urandom % NCH), 0, ($urandom % 4) == 0, 3 + ($urandom % 10),
                1, ($urandom % 3) == 0, -1, ($urandom % 2) == 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule